// File: doc/BRIEF.md
# Iterative Integer Divider

A multi-cycle divider for signed and unsigned two's-complement integers that returns only the quotient. A caller raises `start` for one cycle with the operands, the signedness select and an overflow-enable flag. The block then runs a one-bit-per-cycle restoring divide on the operand magnitudes and fixes the sign of the result in a final cycle. It reports completion with a single-cycle `done` pulse. The quotient and the overflow flag stay on the outputs until the next result replaces them.

Some operand pairs have no representable quotient: any zero divisor, and, in signed mode, the most negative value divided by minus one. A combinational pre-check catches these before any iteration starts. For them the block finishes on the accepting edge with a zero quotient and does not trap. When overflow-enable is set, such a case also raises `ov`, which a status register outside the block may capture. Legal divides never raise `ov`.

A request that arrives while a divide is in flight is dropped, so the caller must wait for `done` before it issues the next operation.

Top module: `int_div_iter`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `busy`, `done`, `ov` and `quotient` are all 0.
- R2: For a legal unsigned divide (`is_signed`=0, divisor nonzero), `quotient` is the floor of dividend/divisor. `done` rises WIDTH+1 clock edges after the edge that accepts `start`. `busy` is 1 from the accepting edge until the edge that raises `done`, and `busy` is 0 while `done` is 1.
- R3: For a legal signed divide (`is_signed`=1), both operands are read as two's complement and `quotient` is their quotient truncated toward zero. The timing is the same as in R2.
- R4: In signed mode, a divisor of 0, or a dividend equal to the most negative value together with a divisor of all ones (-1), gives `quotient`=0. `done` then rises on the accepting edge itself, and `busy` never rises.
- R5: In unsigned mode, a divisor of 0 gives `quotient`=0, with `done` on the accepting edge and `busy` never rising. An all-ones divisor is a legal unsigned divide.
- R6: `ov` is 1 with a result only when `oe` was 1 at acceptance and the case was one of those in R4 or R5. A legal divide, or any divide with `oe`=0, gives `ov`=0.
- R7: `done` is high for exactly one cycle per accepted request. `quotient` and `ov` keep their values until the next result is written.
- R8: A `start` pulse while `busy` is 1 is ignored. The running divide completes with its own operands and produces exactly one `done`.
- R9: A divisor of +1 returns the dividend unchanged, including the most negative value in signed mode. A signed divisor of -1 returns the negated dividend for every dividend except the most negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| dividend | input | WIDTH | Dividend, sampled at acceptance |
| divisor | input | WIDTH | Divisor, sampled at acceptance |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| oe | input | 1 | Overflow enable, 1 lets illegal cases raise `ov` |
| busy | output | 1 | A legal divide is in flight |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Registered quotient, held between results |
| ov | output | 1 | Registered overflow flag, held between results |

## Verification
A miscounted iteration counter shows at the ports as `done` arriving one or more edges away from WIDTH+1. The latency check catches that on the very first legal divide. A corrupted partial remainder or divisor register shows as a wrong `quotient` at the next `done`, within WIDTH+1 edges of the fault. A wrong latched sign flag flips the sign of the result for every mixed-sign pair. An exhaustive sweep of a 5-bit instance reaches every such state, and directed and random 32-bit operations confirm that the width parameter scales correctly.

// File: rtl/div_pkg.sv
package div_pkg;

  // Sequencer states of the divider control
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

endpackage

// File: rtl/div_precheck.sv
// Operand classification: illegal-case detection, magnitudes, result sign.
module div_precheck #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             is_signed,
  output logic             illegal,
  output logic [WIDTH-1:0] mag_dividend,
  output logic [WIDTH-1:0] mag_divisor,
  output logic             neg_result
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic a_neg, b_neg, zero_div, min_by_m1;

  always_comb begin
    a_neg        = is_signed & dividend[WIDTH-1];
    b_neg        = is_signed & divisor[WIDTH-1];
    zero_div     = (divisor == '0);
    min_by_m1    = is_signed && (dividend == MOST_NEG) && (divisor == ALL_ONES);
    illegal      = zero_div | min_by_m1;
    mag_dividend = a_neg ? (~dividend + 1'b1) : dividend;
    mag_divisor  = b_neg ? (~divisor + 1'b1) : divisor;
    neg_result   = a_neg ^ b_neg;
  end

endmodule

// File: rtl/div_core.sv
// Radix-2 restoring divider datapath on unsigned magnitudes.
module div_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] mag_dividend,
  input  logic [WIDTH-1:0] mag_divisor,
  output logic [WIDTH-1:0] quot_mag,
  output logic             last_step
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH:0]   rem_r;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] d_r;
  logic [CNT_W-1:0] cnt_r;

  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   trial;
  logic             fits;

  // One restoring step: shift in the next dividend bit, try the subtract
  always_comb begin
    shifted = {rem_r[WIDTH-1:0], q_r[WIDTH-1]};
    trial   = shifted - {1'b0, d_r};
    fits    = ~trial[WIDTH];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_r <= '0;
      q_r   <= '0;
      d_r   <= '0;
      cnt_r <= '0;
    end else if (load) begin
      rem_r <= '0;
      q_r   <= mag_dividend;
      d_r   <= mag_divisor;
      cnt_r <= CNT_W'(WIDTH);
    end else if (step) begin
      rem_r <= fits ? trial : shifted;
      q_r   <= {q_r[WIDTH-2:0], fits};
      cnt_r <= cnt_r - 1'b1;
    end
  end

  assign quot_mag  = q_r;
  assign last_step = (cnt_r == CNT_W'(1));

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (rem_r < {1'b0, d_r}));

  // R2
  count_live_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt_r != '0));

endmodule

// File: rtl/div_fixup.sv
// Applies the result sign to the unsigned quotient magnitude.
module div_fixup #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] quot_mag,
  input  logic             negate,
  output logic [WIDTH-1:0] quot_final
);
  always_comb begin
    quot_final = negate ? (~quot_mag + 1'b1) : quot_mag;
  end
endmodule

// File: rtl/int_div_iter.sv
// Iterative signed/unsigned integer divider, quotient only.
module int_div_iter #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             is_signed,
  input  logic             oe,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic             ov
);
  import div_pkg::*;

  div_state_e       state_r;
  logic             neg_r;
  logic             illegal_w;
  logic             neg_w;
  logic [WIDTH-1:0] mag_a_w;
  logic [WIDTH-1:0] mag_b_w;
  logic [WIDTH-1:0] quot_mag_w;
  logic [WIDTH-1:0] quot_fix_w;
  logic             last_w;
  logic             accept;
  logic             core_load;
  logic             core_step;

  assign accept    = start && (state_r == ST_IDLE);
  assign core_load = accept && !illegal_w;
  assign core_step = (state_r == ST_RUN);

  div_precheck #(.WIDTH(WIDTH)) u_precheck (
    .dividend     (dividend),
    .divisor      (divisor),
    .is_signed    (is_signed),
    .illegal      (illegal_w),
    .mag_dividend (mag_a_w),
    .mag_divisor  (mag_b_w),
    .neg_result   (neg_w)
  );

  div_core #(.WIDTH(WIDTH)) u_core (
    .clk          (clk),
    .rst          (rst),
    .load         (core_load),
    .step         (core_step),
    .mag_dividend (mag_a_w),
    .mag_divisor  (mag_b_w),
    .quot_mag     (quot_mag_w),
    .last_step    (last_w)
  );

  div_fixup #(.WIDTH(WIDTH)) u_fixup (
    .quot_mag   (quot_mag_w),
    .negate     (neg_r),
    .quot_final (quot_fix_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r  <= ST_IDLE;
      neg_r    <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
      ov       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_r)
        ST_IDLE: begin
          if (accept) begin
            if (illegal_w) begin
              done     <= 1'b1;
              quotient <= '0;
              ov       <= oe;
            end else begin
              state_r <= ST_RUN;
              neg_r   <= neg_w;
            end
          end
        end
        ST_RUN: begin
          if (last_w) state_r <= ST_FIX;
        end
        ST_FIX: begin
          state_r  <= ST_IDLE;
          done     <= 1'b1;
          quotient <= quot_fix_w;
          ov       <= 1'b0;
        end
        default: state_r <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_r != ST_IDLE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4 (and R5)
  illegal_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && illegal_w) |=> (done && !busy && (quotient == '0)));

  // R6
  ov_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ov |-> (quotient == '0));

  // R8
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/int_div_iter_tb.sv
`timescale 1ns/1ps
module int_div_iter_tb;
  localparam int BW = 32;
  localparam int SW = 5;
  localparam int WDOG = 180000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          b_start = 0, b_s = 0, b_oe = 0;
  logic [BW-1:0] b_a = '0, b_b = '0;
  logic          b_busy, b_done, b_ov;
  logic [BW-1:0] b_q;

  logic          s_start = 0, s_s = 0, s_oe = 0;
  logic [SW-1:0] s_a = '0, s_b = '0;
  logic          s_busy, s_done, s_ov;
  logic [SW-1:0] s_q;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int_div_iter #(.WIDTH(BW)) u_dut (
    .clk(clk), .rst(rst), .start(b_start), .dividend(b_a), .divisor(b_b),
    .is_signed(b_s), .oe(b_oe), .busy(b_busy), .done(b_done),
    .quotient(b_q), .ov(b_ov));

  int_div_iter #(.WIDTH(SW)) u_dut_small (
    .clk(clk), .rst(rst), .start(s_start), .dividend(s_a), .divisor(s_b),
    .is_signed(s_s), .oe(s_oe), .busy(s_busy), .done(s_done),
    .quotient(s_q), .ov(s_ov));

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Arithmetic reference: quotient, overflow and illegal flag for width w
  function automatic void ref_div(input longint a, input longint b, input int w,
                                  input bit sg, input bit oe,
                                  output longint q, output bit ov, output bit bad);
    longint m, x, y, full;
    full = longint'(1) << w;
    m = full - 1;
    x = a & m;
    y = b & m;
    if (sg && x >= (full >> 1)) x = x - full;
    if (sg && y >= (full >> 1)) y = y - full;
    bad = (y == 0) || (sg && (x == -(full >> 1)) && (y == -1));
    q   = bad ? 0 : ((x / y) & m);
    ov  = bad && oe;
  endfunction

  task automatic run(input bit big, input longint a, input longint b,
                     input bit sg, input bit oe, input string tag);
    int w;
    longint eq, qa;
    bit eov, bad, ova, bsy0, dn;
    int k;
    string qreq, lreq;
    w = big ? BW : SW;
    ref_div(a, b, w, sg, oe, eq, eov, bad);
    qreq = bad ? (sg ? "R4" : "R5") : (sg ? "R3" : "R2");
    lreq = bad ? (sg ? "R4" : "R5") : "R2";
    @(negedge clk);
    if (big) begin
      b_a = a[BW-1:0]; b_b = b[BW-1:0]; b_s = sg; b_oe = oe; b_start = 1;
    end else begin
      s_a = a[SW-1:0]; s_b = b[SW-1:0]; s_s = sg; s_oe = oe; s_start = 1;
    end
    @(posedge clk);
    @(negedge clk);
    b_start = 0;
    s_start = 0;
    bsy0 = big ? b_busy : s_busy;
    k = 0;
    dn = big ? b_done : s_done;
    while (!dn && k < w + 4) begin
      @(negedge clk);
      k++;
      dn = big ? b_done : s_done;
    end
    qa  = big ? longint'(b_q) : longint'(s_q);
    ova = big ? b_ov : s_ov;
    chk(k == (bad ? 0 : w + 1), lreq, {tag, " done latency"}, k, bad ? 0 : w + 1);
    chk(bsy0 == !bad, lreq, {tag, " busy after accept"}, bsy0, !bad);
    chk(qa == eq, qreq, {tag, " quotient"}, qa, eq);
    chk(ova == eov, "R6", {tag, " ov"}, ova, eov);
    @(negedge clk);
    dn = big ? b_done : s_done;
    chk(!dn, "R7", {tag, " done width"}, dn, 0);
  endtask

  localparam longint MN = 64'h8000_0000;
  localparam longint M1 = 64'hFFFF_FFFF;

  initial begin
    int dones;
    repeat (4) @(negedge clk);
    chk(!b_busy && !b_done && !b_ov && b_q == 0, "R1", "big reset outputs",
        {b_busy, b_done, b_ov, b_q}, 0);
    rst = 0;
    @(negedge clk);
    chk(!b_busy && !b_done && !b_ov && b_q == 0, "R1", "big after release",
        {b_busy, b_done, b_ov, b_q}, 0);
    chk(!s_busy && !s_done && !s_ov && s_q == 0, "R1", "small after release",
        {s_busy, s_done, s_ov, s_q}, 0);

    // Exhaustive sweep of the small instance, all modes
    for (int sg = 0; sg < 2; sg++)
      for (int oe = 0; oe < 2; oe++)
        for (int a = 0; a < (1 << SW); a++)
          for (int b = 0; b < (1 << SW); b++)
            run(1'b0, a, b, sg[0], oe[0], "sweep");

    // Directed 32-bit corners
    run(1'b1, MN, M1, 1'b1, 1'b0, "R4 min by -1");
    run(1'b1, MN, M1, 1'b1, 1'b1, "R4 min by -1 oe");
    run(1'b1, 12345, 0, 1'b1, 1'b1, "R4 zero divisor oe");
    run(1'b1, 12345, 0, 1'b0, 1'b1, "R5 zero divisor oe");
    run(1'b1, 77, 0, 1'b0, 1'b0, "R5 zero divisor");
    run(1'b1, MN, M1, 1'b0, 1'b1, "R5 all-ones legal");
    run(1'b1, M1, 1, 1'b0, 1'b1, "R9 unsigned by 1");
    run(1'b1, MN, 1, 1'b1, 1'b0, "R9 min by +1");
    run(1'b1, 7, M1, 1'b1, 1'b0, "R9 by -1");
    run(1'b1, 64'h8000_0001, M1, 1'b1, 1'b1, "R9 near-min by -1");
    run(1'b1, 7, 64'hFFFF_FFFE, 1'b1, 1'b0, "R3 7 by -2");
    run(1'b1, 64'hFFFF_FFF9, 2, 1'b1, 1'b0, "R3 -7 by 2");
    run(1'b1, 64'hFFFF_FFF9, 2, 1'b0, 1'b0, "R2 unsigned big");

    // Random 32-bit operands
    for (int i = 0; i < 240; i++)
      run(1'b1, longint'($urandom), longint'($urandom >> (i % 31)),
          i[0], i[1], "random");

    // R8: start while busy is dropped
    @(negedge clk);
    b_a = 1000; b_b = 7; b_s = 0; b_oe = 1; b_start = 1;
    @(posedge clk);
    @(negedge clk);
    b_start = 0;
    repeat (3) @(negedge clk);
    b_a = 5; b_b = 0; b_start = 1;
    @(negedge clk);
    b_start = 0;
    dones = 0;
    for (int i = 0; i < 45; i++) begin
      if (b_done) begin
        dones++;
        chk(b_q == 142 && !b_ov, "R8", "busy start quotient", b_q, 142);
      end
      @(negedge clk);
    end
    chk(dones == 1, "R8", "done count", dones, 1);
    // R7: results held after done
    chk(b_q == 142 && !b_done && !b_busy, "R7", "quotient hold", b_q, 142);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule